// File: doc/BRIEF.md
# Command-Address Parity Checker with Shared Alert

This block sits on the command/address input path of a DDR4-style memory device model. On each rising clock edge where chip select is low, it takes the command and address lines together with a separate parity bit and checks them for even parity. The check runs only while a mode-register parity enable is set. A parity failure starts a long recovery interval. During that interval an active-low alert line is held low, and any commands that arrive are flagged as ignored rather than checked.

The same alert line also carries a short low pulse when a write-data CRC error strobe arrives from elsewhere in the device. Both interval lengths are runtime inputs counted in clock cycles. The parity interval is meant to be the longer of the two.

On the first parity failure, the block also sets a sticky error bit and captures the failing command and address word. Both stay held until an explicit clear or a reset. A build parameter selects whether three stacked-die chip-ID bits take part in the parity sum.

Top module: `ca_parity_alert`

## Requirements
- R1: With the default build, the covered word is {act_n, bg[1:0], ba[1:0], addr[17:0], cid[2:0]}, most significant bit first (26 bits). The addr bits 16, 15 and 14 also serve as the row-strobe, column-strobe and write-enable command pins. A checked cycle whose covered word XOR-ed with `par` is 1 is a parity error, and a checked cycle whose XOR is 0 raises nothing.
- R2: A cycle is checked only when `cs_n` is low at the rising edge. With `cs_n` high, a parity mismatch raises no error.
- R3: While `par_en` is low, no parity error is ever raised.
- R4: A parity error sampled at edge k drives `alert_n` low after edge k. It stays low for exactly `par_cycles` cycles (with `par_cycles` at least 1) and then returns high, unless a CRC interval is still running.
- R5: A `crc_err` strobe sampled at edge k drives `alert_n` low after edge k for exactly `crc_cycles` cycles. A new strobe restarts that interval.
- R6: When the parity and CRC intervals overlap, `alert_n` stays low until the later of the two ends.
- R7: A command with `cs_n` low that arrives while a parity recovery interval is running sets `cmd_ignored` high for the following cycle. That command is not checked, so it neither restarts nor lengthens the interval.
- R8: The first parity error sets `par_err_sticky` and loads `err_cmd` with the covered word of the failing command. Later errors leave both unchanged.
- R9: `clr` high at an edge zeroes `par_err_sticky` and `err_cmd`. `clr` wins over an error sampled at the same edge, but the alert for that error still happens.
- R10: After synchronous reset, `alert_n` is 1, and `cmd_ignored`, `par_err_sticky` and `err_cmd` are 0.
- R11: With HAS_CID set to 0, `cid` is left out of the parity sum and `err_cmd` narrows to 23 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low; low marks a command cycle |
| act_n | input | 1 | Activate command line |
| bg | input | BG_W | Bank group bits |
| ba | input | BA_W | Bank address bits |
| addr | input | ADDR_W | Address bits; bits 16..14 double as command strobes |
| cid | input | CID_W | Stacked-die chip-ID bits |
| par | input | 1 | Even parity bit for the covered word |
| par_en | input | 1 | Parity checking enable from the mode register |
| crc_err | input | 1 | Write CRC error strobe |
| clr | input | 1 | Clears the sticky flag and the captured word |
| par_cycles | input | CNT_W | Parity recovery interval in cycles |
| crc_cycles | input | CNT_W | CRC alert interval in cycles |
| alert_n | output | 1 | Shared active-low alert |
| cmd_ignored | output | 1 | Previous command arrived during recovery |
| par_err_sticky | output | 1 | Sticky parity error flag |
| err_cmd | output | PKT_W | Covered word of the first failing command |

## Verification
Several properties are checked on every cycle. The alert must fall right after an accepted parity error or a CRC strobe. A running countdown must fall by one per cycle. An ignored-command flag may only follow a cycle in which the alert was already low. The sticky flag and captured word must hold until cleared, and the sticky flag must stay put while checking is disabled. Other behaviour only the bench's scenarios can show: the exact number of low cycles, the stretch to the later of two overlapping intervals, the content of the captured word, clear-over-error priority, and the exclusion of the chip-ID bits in the narrow build.

// File: rtl/ca_par_pkg.sv
package ca_par_pkg;

  // Width of the covered command word for a given build.
  function automatic int pkt_width(input int aw, input int bgw, input int baw,
                                   input int cw, input bit has_cid);
    return 1 + bgw + baw + aw + (has_cid ? cw : 0);
  endfunction

endpackage

// File: rtl/ca_par_calc.sv
module ca_par_calc
  import ca_par_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BG_W    = 2,
  parameter int BA_W    = 2,
  parameter int CID_W   = 3,
  parameter bit HAS_CID = 1'b1,
  localparam int PKT_W  = pkt_width(ADDR_W, BG_W, BA_W, CID_W, HAS_CID)
) (
  input  logic              act_n,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CID_W-1:0]  cid,
  input  logic              par,
  output logic [PKT_W-1:0]  pkt,
  output logic              mismatch
);

  generate
    if (HAS_CID) begin : g_cid
      assign pkt = {act_n, bg, ba, addr, cid};
    end else begin : g_nocid
      logic unused_cid;
      assign unused_cid = ^cid;
      assign pkt = {act_n, bg, ba, addr};
    end
  endgenerate

  // Even parity: the covered bits and the parity bit XOR to zero when good.
  assign mismatch = ^{pkt, par};

endmodule

// File: rtl/alert_timer.sv
module alert_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             busy_nxt
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (load)
      cnt_nxt = len;
    else if (cnt != '0)
      cnt_nxt = cnt - 1'b1;
    else
      cnt_nxt = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  assign busy     = (cnt != '0);
  assign busy_nxt = (cnt_nxt != '0);

  // R4/R5: an unreloaded interval shrinks by exactly one per cycle
  a_r4_countdown: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ca_par_capture.sv
module ca_par_capture #(
  parameter int PKT_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             err,
  input  logic [PKT_W-1:0] pkt,
  output logic             sticky,
  output logic [PKT_W-1:0] cmd
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sticky <= 1'b0;
      cmd    <= '0;
    end else if (err && !sticky) begin
      sticky <= 1'b1;
      cmd    <= pkt;
    end
  end

  // R8: flag and captured word hold until cleared
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (sticky && !clr) |=> sticky);
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (sticky && !clr) |=> $stable(cmd));
  // R9: clear always empties the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> !sticky);

endmodule

// File: rtl/ca_parity_alert.sv
module ca_parity_alert
  import ca_par_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int BG_W    = 2,
  parameter int BA_W    = 2,
  parameter int CID_W   = 3,
  parameter bit HAS_CID = 1'b1,
  parameter int CNT_W   = 16,
  localparam int PKT_W  = pkt_width(ADDR_W, BG_W, BA_W, CID_W, HAS_CID)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              act_n,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CID_W-1:0]  cid,
  input  logic              par,
  input  logic              par_en,
  input  logic              crc_err,
  input  logic              clr,
  input  logic [CNT_W-1:0]  par_cycles,
  input  logic [CNT_W-1:0]  crc_cycles,
  output logic              alert_n,
  output logic              cmd_ignored,
  output logic              par_err_sticky,
  output logic [PKT_W-1:0]  err_cmd
);

  logic [PKT_W-1:0] pkt;
  logic             mismatch;
  logic             par_busy, par_busy_nxt;
  logic             crc_busy, crc_busy_nxt;
  logic             par_load;

  ca_par_calc #(
    .ADDR_W(ADDR_W), .BG_W(BG_W), .BA_W(BA_W),
    .CID_W(CID_W), .HAS_CID(HAS_CID)
  ) u_calc (
    .act_n(act_n), .bg(bg), .ba(ba), .addr(addr), .cid(cid),
    .par(par), .pkt(pkt), .mismatch(mismatch)
  );

  // An error is accepted only on a selected, enabled cycle outside recovery.
  assign par_load = !cs_n && par_en && !par_busy && mismatch;

  alert_timer #(.CNT_W(CNT_W)) u_par_tmr (
    .clk(clk), .rst(rst), .load(par_load), .len(par_cycles),
    .busy(par_busy), .busy_nxt(par_busy_nxt)
  );

  alert_timer #(.CNT_W(CNT_W)) u_crc_tmr (
    .clk(clk), .rst(rst), .load(crc_err), .len(crc_cycles),
    .busy(crc_busy), .busy_nxt(crc_busy_nxt)
  );

  ca_par_capture #(.PKT_W(PKT_W)) u_cap (
    .clk(clk), .rst(rst), .clr(clr), .err(par_load), .pkt(pkt),
    .sticky(par_err_sticky), .cmd(err_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_n     <= 1'b1;
      cmd_ignored <= 1'b0;
    end else begin
      alert_n     <= !(par_busy_nxt || crc_busy_nxt);
      cmd_ignored <= !cs_n && par_busy;
    end
  end

  // R4: an accepted parity error pulls the alert low next cycle
  a_r4_err_alert: assert property (@(posedge clk) disable iff (rst)
    (par_load && par_cycles != '0) |=> !alert_n);
  // R5: a CRC strobe pulls the alert low next cycle
  a_r5_crc_alert: assert property (@(posedge clk) disable iff (rst)
    (crc_err && crc_cycles != '0) |=> !alert_n);
  // R7: commands are only reported ignored while the alert was already low
  a_r7_ignored_in_recovery: assert property (@(posedge clk) disable iff (rst)
    cmd_ignored |-> $past(!alert_n));
  // R3: with checking disabled the sticky flag cannot change on its own
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!par_en && !clr) |=> $stable(par_err_sticky));

endmodule

// File: tb/ca_parity_alert_tb.sv
module ca_parity_alert_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, cs_n, act_n, par, par_en, crc_err, clr;
  logic [1:0]  bg, ba;
  logic [17:0] addr;
  logic [2:0]  cid;
  logic [15:0] par_cycles, crc_cycles;
  logic        alert_n, cmd_ignored, par_err_sticky;
  logic [25:0] err_cmd;
  logic        nc_alert_n, nc_ignored, nc_sticky;
  logic [22:0] nc_cmd;

  ca_parity_alert u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .act_n(act_n), .bg(bg), .ba(ba),
    .addr(addr), .cid(cid), .par(par), .par_en(par_en), .crc_err(crc_err),
    .clr(clr), .par_cycles(par_cycles), .crc_cycles(crc_cycles),
    .alert_n(alert_n), .cmd_ignored(cmd_ignored),
    .par_err_sticky(par_err_sticky), .err_cmd(err_cmd)
  );

  ca_parity_alert #(.HAS_CID(1'b0)) u_dut_nc (
    .clk(clk), .rst(rst), .cs_n(cs_n), .act_n(act_n), .bg(bg), .ba(ba),
    .addr(addr), .cid(cid), .par(par), .par_en(par_en), .crc_err(crc_err),
    .clr(clr), .par_cycles(par_cycles), .crc_cycles(crc_cycles),
    .alert_n(nc_alert_n), .cmd_ignored(nc_ignored),
    .par_err_sticky(nc_sticky), .err_cmd(nc_cmd)
  );

  typedef struct {
    logic        alert_n;
    logic        ign;
    logic        sticky;
    logic [25:0] cmd;
    logic        nc_sticky;
    string       tag;
  } exp_t;

  typedef struct {
    int unsigned pc;
    int unsigned cc;
    logic        st;
    logic [25:0] cmd;
  } mdl_t;

  exp_t q[$];
  mdl_t m_main, m_nc;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  // Behavioural expectation for one edge, written from the requirements.
  function automatic mdl_t mstep(input mdl_t s, input logic [25:0] pk,
                                 input logic use_cid, input logic p,
                                 input logic csn, input logic crc, input logic cl,
                                 output logic a, output logic ig);
    mdl_t n;
    logic mm, recov, e;
    n     = s;
    recov = (s.pc != 0);
    mm    = use_cid ? (^pk ^ p) : (^pk[25:3] ^ p);
    e     = !csn && par_en && !recov && mm;
    ig    = !csn && recov;
    n.pc  = e ? int'(par_cycles) : (recov ? s.pc - 1 : 0);
    n.cc  = crc ? int'(crc_cycles) : (s.cc != 0 ? s.cc - 1 : 0);
    if (cl) begin
      n.st  = 1'b0;
      n.cmd = '0;
    end else if (e && !s.st) begin
      n.st  = 1'b1;
      n.cmd = pk;
    end
    a = (n.pc == 0) && (n.cc == 0);
    return n;
  endfunction

  task automatic step(input logic csn, input logic [25:0] pk, input logic p,
                      input logic crc, input logic cl, input string tag);
    exp_t e;
    logic a1, i1, a2, i2;
    @(negedge clk);
    cs_n = csn;
    {act_n, bg, ba, addr, cid} = pk;
    par = p;
    crc_err = crc;
    clr = cl;
    m_main = mstep(m_main, pk, 1'b1, p, csn, crc, cl, a1, i1);
    m_nc   = mstep(m_nc,   pk, 1'b0, p, csn, crc, cl, a2, i2);
    e.alert_n   = a1;
    e.ign       = i1;
    e.sticky    = m_main.st;
    e.cmd       = m_main.cmd;
    e.nc_sticky = m_nc.st;
    e.tag       = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 26'h0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  function automatic logic [25:0] mk(input logic an, input logic [1:0] g,
                                     input logic [1:0] b, input logic [17:0] a,
                                     input logic [2:0] c);
    return {an, g, b, a, c};
  endfunction

  // Monitor: pops one expected item per edge and compares
  exp_t got;
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      got = q.pop_front();
      checks++;
      if (alert_n !== got.alert_n || cmd_ignored !== got.ign ||
          par_err_sticky !== got.sticky || err_cmd !== got.cmd ||
          nc_sticky !== got.nc_sticky) begin
        failures++;
        $display("FAIL %s actual alert_n=%b ign=%b sticky=%b cmd=%h nc_sticky=%b expected alert_n=%b ign=%b sticky=%b cmd=%h nc_sticky=%b",
                 got.tag, alert_n, cmd_ignored, par_err_sticky, err_cmd, nc_sticky,
                 got.alert_n, got.ign, got.sticky, got.cmd, got.nc_sticky);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [25:0] pk, pe, pe2;
    m_main = '{pc: 0, cc: 0, st: 1'b0, cmd: '0};
    m_nc   = '{pc: 0, cc: 0, st: 1'b0, cmd: '0};
    rst = 1'b1; cs_n = 1'b1; act_n = 1'b1; bg = '0; ba = '0; addr = '0; cid = '0;
    par = 1'b0; par_en = 1'b1; crc_err = 1'b0; clr = 1'b0;
    par_cycles = 16'd12; crc_cycles = 16'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: state right after reset
    checks++;
    if (alert_n !== 1'b1 || cmd_ignored !== 1'b0 || par_err_sticky !== 1'b0 || err_cmd !== '0) begin
      failures++;
      $display("FAIL R10 actual alert_n=%b ign=%b sticky=%b cmd=%h expected 1 0 0 0",
               alert_n, cmd_ignored, par_err_sticky, err_cmd);
    end

    // R1: good parity on several patterns
    pk = mk(1'b0, 2'b10, 2'b01, 18'h2A5C3, 3'b101); step(1'b0, pk, ^pk, 1'b0, 1'b0, "R1");
    pk = mk(1'b1, 2'b11, 2'b11, 18'h3FFFF, 3'b111); step(1'b0, pk, ^pk, 1'b0, 1'b0, "R1");
    pk = mk(1'b1, 2'b00, 2'b00, 18'h1C000, 3'b000); step(1'b0, pk, ^pk, 1'b0, 1'b0, "R1");
    pk = mk(1'b0, 2'b01, 2'b10, 18'h00001, 3'b010); step(1'b0, pk, ^pk, 1'b0, 1'b0, "R1");
    // R2: mismatch with chip select high
    pk = mk(1'b0, 2'b01, 2'b00, 18'h12345, 3'b001); step(1'b1, pk, ~^pk, 1'b0, 1'b0, "R2");
    idle(2, "R2");
    // R3: mismatch with checking disabled
    par_en = 1'b0;
    step(1'b0, pk, ~^pk, 1'b0, 1'b0, "R3");
    idle(2, "R3");
    par_en = 1'b1;

    // R4/R7/R8: parity error, commands during recovery ignored
    pe = mk(1'b0, 2'b10, 2'b11, 18'h0BEEF, 3'b110);
    step(1'b0, pe, ~^pe, 1'b0, 1'b0, "R4");
    idle(3, "R4");
    pk = mk(1'b1, 2'b00, 2'b01, 18'h00F0F, 3'b011);
    step(1'b0, pk, ~^pk, 1'b0, 1'b0, "R7");
    step(1'b0, pk, ^pk, 1'b0, 1'b0, "R7");
    idle(5, "R4");
    step(1'b0, pk, ~^pk, 1'b0, 1'b0, "R7");
    idle(4, "R4");
    // R8: second error keeps first capture
    pe2 = mk(1'b1, 2'b01, 2'b01, 18'h20202, 3'b100);
    step(1'b0, pe2, ~^pe2, 1'b0, 1'b0, "R8");
    idle(14, "R8");

    // R9: clear, then clear together with a new error
    step(1'b1, 26'h0, 1'b0, 1'b0, 1'b1, "R9");
    step(1'b0, pe2, ~^pe2, 1'b0, 1'b1, "R9");
    idle(14, "R9");

    // R5: CRC pulse and restart
    step(1'b1, 26'h0, 1'b0, 1'b1, 1'b0, "R5");
    idle(6, "R5");
    step(1'b1, 26'h0, 1'b0, 1'b1, 1'b0, "R5");
    idle(2, "R5");
    step(1'b1, 26'h0, 1'b0, 1'b1, 1'b0, "R5");
    idle(6, "R5");

    // R6: CRC inside a parity interval, ending later and ending earlier
    step(1'b0, pe, ~^pe, 1'b0, 1'b0, "R6");
    idle(9, "R6");
    step(1'b1, 26'h0, 1'b0, 1'b1, 1'b0, "R6");
    idle(7, "R6");
    step(1'b0, pe, ~^pe, 1'b0, 1'b0, "R6");
    idle(1, "R6");
    step(1'b1, 26'h0, 1'b0, 1'b1, 1'b0, "R6");
    idle(13, "R6");

    // R11: chip-ID bits only counted in the default build
    step(1'b1, 26'h0, 1'b0, 1'b0, 1'b1, "R11");
    pk = mk(1'b0, 2'b00, 2'b00, 18'h0, 3'b001);
    step(1'b0, pk, 1'b0, 1'b0, 1'b0, "R11");
    idle(14, "R11");
    step(1'b1, 26'h0, 1'b0, 1'b0, 1'b1, "R11");
    step(1'b0, pk, 1'b1, 1'b0, 1'b0, "R11");
    idle(14, "R11");

    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule